// File: doc/BRIEF.md
# Rotate and Mask Unit

This block takes a 32-bit source word, rotates it to the left, and then combines the rotated word with a bit mask built from two indices. The result goes to a destination. The rotate amount comes from one of two places, chosen by a select input: a 5-bit immediate, or the low bits of a register operand. The two mask indices give a begin position and an end position. Both count from bit 0, and bit 0 is the most significant bit of the word. If the begin index is larger than the end index, the mask wraps around the end of the word.

The unit has two ways to merge. In the zeroing merge, every bit outside the mask becomes 0. In the insert merge, every bit outside the mask keeps its value from the old destination word that comes in with the operation. An operation can also ask to record. A recording operation writes a 4-bit condition field, which describes the signed result compared with zero and carries a copy of a summary-overflow input. An operation that does not record leaves that field unchanged.

The unit is a single registered stage. It accepts one operation on every clock cycle that in_valid is high, and it presents that operation's outputs one cycle later.

Top module: `rotmask_unit`

## Requirements
- R1: The source word is rotated left by the selected amount. Bits that leave the most significant end enter at the least significant end. Example: 0x88776655 rotated by 16 gives 0x66558877, and with begin 16 and end 23 the zeroing result is 0x00008800.
- R2: When amt_sel_reg is 1, the rotate amount is amt_reg[4:0], and the upper 27 bits of amt_reg have no effect. When amt_sel_reg is 0, the rotate amount is amt_imm.
- R3: When mask_begin <= mask_end, the mask has ones at positions begin through end inclusive and zeros elsewhere. Position p maps to port bit 31-p.
- R4: When mask_begin > mask_end, the mask has ones from begin through 31 and from 0 through end, and zeros from end+1 through begin-1. In particular, begin = end+1 gives an all-ones mask.
- R5: With insert_mode = 0, each result bit outside the mask is 0, and each bit inside the mask equals the rotated source bit.
- R6: With insert_mode = 1, each result bit outside the mask equals the matching bit of dst_old, and each bit inside the mask equals the rotated source bit.
- R7: A valid operation with record = 1 sets flags_valid one cycle later. In the same cycle, flags is written as {LT, GT, EQ, SO} in bits [3:0]. LT, GT and EQ compare the result, read as signed, with zero. SO copies so_in.
- R8: A valid operation with record = 0 gives flags_valid = 0 one cycle later, and flags keeps its previous value.
- R9: out_valid equals in_valid delayed by one cycle, and a new operation is accepted on every cycle. When in_valid is 0, result holds its last value.
- R10: While reset is asserted (rst_n low), out_valid, flags_valid, result and flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| src_word | input | 32 | Word to rotate |
| dst_old | input | 32 | Previous destination value, used by the insert merge |
| amt_imm | input | 5 | Immediate rotate amount |
| amt_reg | input | 32 | Register operand; only bits [4:0] are used |
| amt_sel_reg | input | 1 | 1 selects amt_reg as the rotate amount |
| mask_begin | input | 5 | First mask position (0 is the MSB) |
| mask_end | input | 5 | Last mask position (0 is the MSB) |
| insert_mode | input | 1 | 1 selects the insert merge, 0 the zeroing merge |
| record | input | 1 | 1 requests a condition field update |
| so_in | input | 1 | Summary-overflow value copied into the field |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Merged result |
| flags | output | 4 | Condition field {LT, GT, EQ, SO} |
| flags_valid | output | 1 | flags was written this cycle |

## Verification
The rotate, the mask generation and the merge all act in the same cycle on every operation. A recording operation adds a condition field update that depends on the merged result in that same cycle. The stimulus runs back-to-back operations in which recording and non-recording forms, both merge modes, both amount sources, and wrapping and non-wrapping masks are mixed at random. Each cycle's result, flags_valid and flags are compared with a model in the bench that composes the same steps independently. The model also tracks the last recorded field, so it can check that a non-recording operation which follows a recording one leaves the field untouched.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;

  // Condition field layout: bit 3 LT, bit 2 GT, bit 1 EQ, bit 0 SO
  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } cond_field_t;

  typedef enum logic {
    MERGE_ZERO   = 1'b0,
    MERGE_INSERT = 1'b1
  } merge_mode_e;

endpackage

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  output logic [W-1:0]  dout
);

  // stage[s] holds the word after the amount bits below s have been applied
  logic [W-1:0] stage [0:AW];

  assign stage[0] = din;

  for (genvar s = 0; s < AW; s++) begin : g_stage
    localparam int SH = 1 << s;
    assign stage[s+1] = amt[s] ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]}
                               : stage[s];
  end

  assign dout = stage[AW];

endmodule

// File: rtl/rotmask_maskgen.sv
module rotmask_maskgen #(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic [AW-1:0] first_pos,
  input  logic [AW-1:0] last_pos,
  output logic [W-1:0]  mask,
  output logic          wraps
);

  // Decides whether MSB-first position p is inside the mask
  function automatic logic in_span(input int p, input logic [AW-1:0] b,
                                   input logic [AW-1:0] e);
    logic ge_b, le_e;
    ge_b = (p >= int'(b));
    le_e = (p <= int'(e));
    if (b <= e) return ge_b && le_e;
    else        return ge_b || le_e;
  endfunction

  assign wraps = (first_pos > last_pos);

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int POS = W - 1 - i;
    assign mask[i] = in_span(POS, first_pos, last_pos);
  end

endmodule

// File: rtl/rotmask_merge.sv
module rotmask_merge
  import rotmask_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] rotated,
  input  logic [W-1:0] mask,
  input  logic [W-1:0] dst_old,
  input  merge_mode_e  mode,
  input  logic         so_in,
  output logic [W-1:0] merged,
  output cond_field_t  cond
);

  function automatic logic [W-1:0] blend(input logic [W-1:0] r,
                                         input logic [W-1:0] m,
                                         input logic [W-1:0] d,
                                         input merge_mode_e md);
    logic [W-1:0] keep;
    keep = (md == MERGE_INSERT) ? (d & ~m) : '0;
    return (r & m) | keep;
  endfunction

  function automatic cond_field_t compare_zero(input logic [W-1:0] v,
                                               input logic so);
    cond_field_t c;
    c.lt = v[W-1];
    c.eq = (v == '0);
    c.gt = !c.lt && !c.eq;
    c.so = so;
    return c;
  endfunction

  assign merged = blend(rotated, mask, dst_old, mode);
  assign cond   = compare_zero(merged, so_in);

endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  src_word,
  input  logic [W-1:0]  dst_old,
  input  logic [AW-1:0] amt_imm,
  input  logic [W-1:0]  amt_reg,
  input  logic          amt_sel_reg,
  input  logic [AW-1:0] mask_begin,
  input  logic [AW-1:0] mask_end,
  input  logic          insert_mode,
  input  logic          record,
  input  logic          so_in,
  output logic          out_valid,
  output logic [W-1:0]  result,
  output logic [3:0]    flags,
  output logic          flags_valid
);

  // Named internal events for the checks below
  logic [AW-1:0] amt_w;
  logic [W-1:0]  rot_w;
  logic [W-1:0]  mask_w;
  logic          wrap_w;
  logic [W-1:0]  merged_w;
  cond_field_t   cond_w;
  logic          rec_fire_w;
  logic          unused_amt_hi;

  assign amt_w         = amt_sel_reg ? amt_reg[AW-1:0] : amt_imm;
  assign unused_amt_hi = ^amt_reg[W-1:AW];
  assign rec_fire_w    = in_valid && record;

  rotmask_rotator #(.W(W), .AW(AW)) u_rot (
    .din  (src_word),
    .amt  (amt_w),
    .dout (rot_w)
  );

  rotmask_maskgen #(.W(W), .AW(AW)) u_mask (
    .first_pos (mask_begin),
    .last_pos  (mask_end),
    .mask      (mask_w),
    .wraps     (wrap_w)
  );

  rotmask_merge #(.W(W)) u_merge (
    .rotated (rot_w),
    .mask    (mask_w),
    .dst_old (dst_old),
    .mode    (merge_mode_e'(insert_mode)),
    .so_in   (so_in),
    .merged  (merged_w),
    .cond    (cond_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      flags_valid <= 1'b0;
      result      <= '0;
      flags       <= '0;
    end else begin
      out_valid   <= in_valid;
      flags_valid <= rec_fire_w;
      if (in_valid)   result <= merged_w;
      if (rec_fire_w) flags  <= cond_w;
    end
  end

  // R1
  rot_popcount_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ($countones(rot_w) == $countones(src_word)));

  // R3
  single_bit_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mask_begin == mask_end) |-> ($countones(mask_w) == 1));

  // R4
  wrap_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && wrap_w && mask_begin == mask_end + 1'b1) |-> (mask_w == '1));

  // R5
  zero_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !insert_mode) |=> ((result & ~$past(mask_w)) == '0));

  // R6
  insert_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && insert_mode) |=>
      (((result ^ $past(dst_old)) & ~$past(mask_w)) == '0));

  // R7
  flags_one_cmp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flags_valid |-> ($countones(flags[3:1]) == 1 && out_valid));

  // R8
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_fire_w |=> ($stable(flags) && !flags_valid));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

endmodule

// File: tb/tb_rotmask_unit.sv
module tb_rotmask_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] src_word = '0, dst_old = '0, amt_reg = '0;
  logic [4:0]  amt_imm = '0, mask_begin = '0, mask_end = '0;
  logic        amt_sel_reg = 1'b0, insert_mode = 1'b0, record = 1'b0, so_in = 1'b0;
  logic        out_valid, flags_valid;
  logic [31:0] result;
  logic [3:0]  flags;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;
  logic [3:0]  model_flags = '0;
  logic [31:0] model_result = '0;

  always #2 clk = ~clk;

  rotmask_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_word(src_word),
    .dst_old(dst_old), .amt_imm(amt_imm), .amt_reg(amt_reg),
    .amt_sel_reg(amt_sel_reg), .mask_begin(mask_begin), .mask_end(mask_end),
    .insert_mode(insert_mode), .record(record), .so_in(so_in),
    .out_valid(out_valid), .result(result), .flags(flags),
    .flags_valid(flags_valid)
  );

  function automatic logic [31:0] ref_rotl(input logic [31:0] x, input int n);
    logic [63:0] dbl;
    dbl = {x, x} << n;
    return dbl[63:32];
  endfunction

  function automatic logic [31:0] ref_mask(input int b, input int e);
    logic [31:0] m = '0;
    for (int p = 0; p < 32; p++) begin
      if ((b <= e && p >= b && p <= e) || (b > e && (p >= b || p <= e)))
        m[31-p] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [3:0] ref_flags(input logic [31:0] r, input logic so);
    if ($signed(r) < 0)  return {3'b100, so};
    if ($signed(r) > 0)  return {3'b010, so};
    return {3'b001, so};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, then check after the next rising edge
  task automatic step(input logic v, input logic [31:0] s, input logic [31:0] d,
                      input logic sel, input logic [4:0] imm, input logic [31:0] areg,
                      input logic [4:0] b, input logic [4:0] e, input logic ins,
                      input logic rec, input logic so, input string req);
    int amt;
    logic [31:0] r;
    @(negedge clk);
    in_valid = v; src_word = s; dst_old = d; amt_sel_reg = sel; amt_imm = imm;
    amt_reg = areg; mask_begin = b; mask_end = e; insert_mode = ins;
    record = rec; so_in = so;
    amt = sel ? int'(areg[4:0]) : int'(imm);
    r = ref_rotl(s, amt) & ref_mask(int'(b), int'(e));
    if (ins) r = r | (d & ~ref_mask(int'(b), int'(e)));
    if (v) model_result = r;
    if (v && rec) model_flags = ref_flags(r, so);
    @(posedge clk);
    #1;
    chk({req, " R9 out_valid"}, {31'd0, out_valid}, {31'd0, v});
    chk({req, " result"}, result, model_result);
    chk({req, " R7/R8 flags_valid"}, {31'd0, flags_valid}, {31'd0, v && rec});
    chk({req, " R7/R8 flags"}, {28'd0, flags}, {28'd0, model_flags});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    chk("R10 out_valid", {31'd0, out_valid}, 32'd0);
    chk("R10 result", result, 32'd0);
    chk("R10 flags", {28'd0, flags}, 32'd0);
    chk("R10 flags_valid", {31'd0, flags_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R3 R5: worked example
    step(1, 32'h88776655, 32'hFFEEDDCC, 0, 5'd16, 32'h0, 5'd16, 5'd23, 0, 0, 0, "R1 R3 R5 example");
    chk("R1 R5 example value", result, 32'h00008800);
    // R6: insert keeps old destination outside the mask
    step(1, 32'h88776655, 32'hFFEEDDCC, 0, 5'd16, 32'h0, 5'd16, 5'd23, 1, 0, 0, "R6 insert");
    chk("R6 insert value", result, 32'hFFEE88CC);
    // R2: register amount, upper bits ignored
    step(1, 32'h88776655, 32'h0, 1, 5'd3, 32'hABCDE010, 5'd16, 5'd23, 0, 0, 0, "R2 reg amount");
    chk("R2 reg amount value", result, 32'h00008800);
    // R4: wrapping mask
    step(1, 32'h12345678, 32'h0, 0, 5'd0, 32'h0, 5'd24, 5'd7, 0, 0, 0, "R4 wrap");
    chk("R4 wrap value", result, 32'h12000078);
    step(1, 32'hDEADBEEF, 32'h0, 0, 5'd0, 32'h0, 5'd5, 5'd4, 0, 0, 0, "R4 full wrap");
    chk("R4 full wrap value", result, 32'hDEADBEEF);
    // R3: single-bit mask at the MSB and at the LSB
    step(1, 32'hFFFFFFFF, 32'h0, 0, 5'd7, 32'h0, 5'd0, 5'd0, 0, 0, 0, "R3 msb bit");
    chk("R3 msb bit value", result, 32'h80000000);
    step(1, 32'hFFFFFFFF, 32'h0, 0, 5'd7, 32'h0, 5'd31, 5'd31, 0, 0, 0, "R3 lsb bit");
    chk("R3 lsb bit value", result, 32'h00000001);
    // R7: record forms
    step(1, 32'h80000000, 32'h0, 0, 5'd0, 32'h0, 5'd0, 5'd31, 0, 1, 1, "R7 negative");
    chk("R7 LT|SO", {28'd0, flags}, 32'h9);
    step(1, 32'h12345678, 32'h0, 0, 5'd0, 32'h0, 5'd31, 5'd31, 0, 1, 0, "R7 zero");
    chk("R7 EQ", {28'd0, flags}, 32'h2);
    // R8: non-record leaves the field alone
    step(1, 32'h00000001, 32'h0, 0, 5'd0, 32'h0, 5'd0, 5'd31, 0, 0, 1, "R8 no record");
    chk("R8 held", {28'd0, flags}, 32'h2);
    // R9: idle cycle holds the result
    step(0, 32'hFFFFFFFF, 32'hFFFFFFFF, 0, 5'd9, 32'h0, 5'd0, 5'd31, 1, 1, 1, "R9 idle");

    // Random back-to-back mix
    for (int k = 0; k < 600; k++) begin
      logic v;
      v = ($urandom % 8) != 0;
      step(v, $urandom, $urandom, $urandom % 2, 5'($urandom), $urandom,
           5'($urandom), 5'($urandom), $urandom % 2, $urandom % 2, $urandom % 2,
           "R1-mix random");
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule